// File: doc/BRIEF.md
# Active-Power Sign and No-Load Event Monitor

This block watches a stream of signed, already calibrated active-power samples, qualified by a valid strobe. It reports two kinds of events through sticky status bits. The first is a change of power sign in a direction chosen by a mode input. The second is a no-load condition, where the magnitude of a sample falls under one of three thresholds picked by a 2-bit select. Each status bit is masked by its own enable bit, and the results are ORed onto one level-sensitive interrupt line. Software clears a status bit by writing a one to it.

The block also drives an accumulate-enable output for a downstream energy accumulator. That output drops while the most recent valid sample lay under the active no-load threshold, which keeps very small loads from creeping into the energy total. It stays high whenever no-load detection is switched off. The full-scale power magnitude is a parameter (default 838861). The three thresholds are integer compare constants derived from it by rounding: 126, 63 and 31 LSB by default. An asynchronous active-low reset is released through a two-stage synchronizer, so the block begins to act on the third rising clock edge after reset is released.

Top module: `pwr_event_monitor`

## Requirements
- R1: With `dir_mode_i` = 0, a valid sample with a negative value (bit DW-1 set) that follows a valid non-negative sample sets status bit 0 (sign event) on the next clock edge.
- R2: With `dir_mode_i` = 1, a valid non-negative sample that follows a valid negative sample sets status bit 0. A transition in the other direction does not set it.
- R3: Sign tracking uses valid samples only, and a zero sample counts as positive. The first valid sample after reset never produces a sign event. Samples presented with `smp_valid_i` low have no effect.
- R4: `nl_sel_i` codes: 00 turns no-load detection off, 01 uses a threshold of 126, 10 uses 63, and 11 uses 31. A valid sample whose absolute value is strictly below the selected threshold sets status bit 1 (no-load event). With code 00 this bit is never set.
- R5: `acc_en_o` is low while detection is on and the most recent valid sample was under the threshold that applied when it arrived. Otherwise it is high, and it goes high at once when `nl_sel_i` is 00.
- R6: `irq_o` is high exactly when some status bit is set and its matching bit of `irq_en_i` is set (bit 0 sign, bit 1 no-load).
- R7: A status bit stays set until a cycle with `clr_wr_i` high and the matching `clr_data_i` bit at 1 clears it. Clear writes with a 0 in that bit leave it unchanged.
- R8: When a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: During and after reset, `status_o` is 0, `irq_o` is 0 and `acc_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DW | Signed two's-complement active-power sample |
| dir_mode_i | input | 1 | Sign-event direction: 0 positive-to-negative, 1 negative-to-positive |
| nl_sel_i | input | 2 | No-load threshold select |
| irq_en_i | input | 2 | Interrupt enables, bit 0 sign, bit 1 no-load |
| clr_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| clr_data_i | input | 2 | Status bits to clear |
| status_o | output | 2 | Sticky status, bit 0 sign, bit 1 no-load |
| irq_o | output | 1 | Masked interrupt request |
| acc_en_o | output | 1 | Energy accumulation enable |

## Verification
The hardest case to reach from the ports is a set event landing in the same cycle as a clear of the same bit. A sample can only set the flag once it is compared with the previous valid sample, and the clear is a separate strobe, so the two have to be lined up by hand. The bench drives a below-threshold sample on the same falling edge as the clear write. It does the same for the first-sample case by pulsing reset in the middle of the test and starting with a negative value, which would look like a transition if the previous sign were assumed positive. A long random phase then mixes small-magnitude samples, select changes, direction flips and clears, and every clock is compared with a behavioural model.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;

  localparam int unsigned NFLAG     = 2;
  localparam int unsigned FLAG_SIGN = 0;
  localparam int unsigned FLAG_NL   = 1;

  typedef enum logic [1:0] {
    NL_OFF = 2'b00,
    NL_HI  = 2'b01,
    NL_MID = 2'b10,
    NL_LO  = 2'b11
  } nl_sel_e;

  // Rounded integer threshold for a select code, scaled from full scale.
  function automatic longint unsigned nl_limit(input longint unsigned fs,
                                               input logic [1:0] code);
    longint unsigned r;
    case (code)
      2'b01:   r = (fs * 64'd15 + 64'd50000)  / 64'd100000;
      2'b10:   r = (fs * 64'd75 + 64'd500000) / 64'd1000000;
      2'b11:   r = (fs * 64'd37 + 64'd500000) / 64'd1000000;
      default: r = 64'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwr_sign_detect.sv
module pwr_sign_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic neg_i,
  input  logic dir_i,
  output logic event_o
);

  logic have_q, have_d;
  logic prev_neg_q, prev_neg_d;
  logic fall, rise;

  always_comb begin
    fall    = have_q && !prev_neg_q &&  neg_i;
    rise    = have_q &&  prev_neg_q && !neg_i;
    event_o = valid_i && (dir_i ? rise : fall);
  end

  always_comb begin
    have_d     = have_q;
    prev_neg_d = prev_neg_q;
    if (valid_i) begin
      have_d     = 1'b1;
      prev_neg_d = neg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      prev_neg_q <= 1'b0;
    end else begin
      have_q     <= have_d;
      prev_neg_q <= prev_neg_d;
    end
  end

endmodule

// File: rtl/pwr_noload_detect.sv
module pwr_noload_detect
  import pwr_mon_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter longint unsigned FS = 64'd838861
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [DW-1:0] sample_i,
  input  logic [1:0]    sel_i,
  output logic          event_o,
  output logic          acc_en_o
);

  localparam longint unsigned LIM_HI  = nl_limit(FS, 2'b01);
  localparam longint unsigned LIM_MID = nl_limit(FS, 2'b10);
  localparam longint unsigned LIM_LO  = nl_limit(FS, 2'b11);
  localparam logic [DW:0] TH_HI  = LIM_HI[DW:0];
  localparam logic [DW:0] TH_MID = LIM_MID[DW:0];
  localparam logic [DW:0] TH_LO  = LIM_LO[DW:0];

  logic [DW:0] ext;
  logic [DW:0] mag;
  logic [DW:0] thr;
  logic        below;
  logic        below_q, below_d;

  always_comb begin
    ext = {sample_i[DW-1], sample_i};
    mag = sample_i[DW-1] ? (~ext + 1'b1) : ext;
    unique case (nl_sel_e'(sel_i))
      NL_HI:   thr = TH_HI;
      NL_MID:  thr = TH_MID;
      NL_LO:   thr = TH_LO;
      default: thr = '0;
    endcase
    below   = (nl_sel_e'(sel_i) != NL_OFF) && (mag < thr);
    event_o = valid_i && below;
  end

  always_comb begin
    below_d = below_q;
    if (valid_i) below_d = below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) below_q <= 1'b0;
    else        below_q <= below_d;
  end

  assign acc_en_o = (nl_sel_e'(sel_i) == NL_OFF) || !below_q;

endmodule

// File: rtl/pwr_irq_flags.sv
module pwr_irq_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);

  logic [N-1:0] flag_q;
  logic [N-1:0] pend;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt;
    always_comb begin
      nxt = flag_q[i];
      if (clr_wr_i && clr_mask_i[i]) nxt = 1'b0;
      if (set_i[i])                  nxt = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= nxt;
    end
    assign pend[i] = flag_q[i] && en_i[i];
  end

  assign status_o = flag_q;
  assign irq_o    = |pend;

endmodule

// File: rtl/pwr_event_monitor.sv
module pwr_event_monitor
  import pwr_mon_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter longint unsigned FS = 64'd838861
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic          dir_mode_i,
  input  logic [1:0]    nl_sel_i,
  input  logic [1:0]    irq_en_i,
  input  logic          clr_wr_i,
  input  logic [1:0]    clr_data_i,
  output logic [1:0]    status_o,
  output logic          irq_o,
  output logic          acc_en_o
);

  logic             rst_int_n;
  logic             sign_evt;
  logic             nl_evt;
  logic [NFLAG-1:0] set_vec;

  pwr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pwr_sign_detect u_sign (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .valid_i (smp_valid_i),
    .neg_i   (smp_data_i[DW-1]),
    .dir_i   (dir_mode_i),
    .event_o (sign_evt)
  );

  pwr_noload_detect #(.DW(DW), .FS(FS)) u_nl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .valid_i  (smp_valid_i),
    .sample_i (smp_data_i),
    .sel_i    (nl_sel_i),
    .event_o  (nl_evt),
    .acc_en_o (acc_en_o)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_SIGN] = sign_evt;
    set_vec[FLAG_NL]   = nl_evt;
  end

  pwr_irq_flags #(.N(NFLAG)) u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_i      (set_vec),
    .clr_wr_i   (clr_wr_i),
    .clr_mask_i (clr_data_i),
    .en_i       (irq_en_i),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/pwr_event_monitor_chk.sv
module pwr_event_monitor_chk
  import pwr_mon_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter longint unsigned FS = 64'd838861
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid_i,
  input logic [DW-1:0] smp_data_i,
  input logic          dir_mode_i,
  input logic [1:0]    nl_sel_i,
  input logic [1:0]    irq_en_i,
  input logic          clr_wr_i,
  input logic [1:0]    clr_data_i,
  input logic [1:0]    status_o,
  input logic          irq_o,
  input logic          acc_en_o
);

  localparam longint unsigned C_HI  = nl_limit(FS, 2'b01);
  localparam longint unsigned C_MID = nl_limit(FS, 2'b10);
  localparam longint unsigned C_LO  = nl_limit(FS, 2'b11);

  logic          seen_c;
  logic          last_neg_c;
  logic [DW:0]   abs_c;
  longint unsigned lim_c;
  logic          small_c;
  logic          neg_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_c     <= 1'b0;
      last_neg_c <= 1'b0;
    end else if (smp_valid_i) begin
      seen_c     <= 1'b1;
      last_neg_c <= smp_data_i[DW-1];
    end
  end

  always_comb begin
    neg_c = smp_data_i[DW-1];
    abs_c = neg_c ? ({1'b0, ~smp_data_i} + 1'b1) : {1'b0, smp_data_i};
    case (nl_sel_i)
      2'b01:   lim_c = C_HI;
      2'b10:   lim_c = C_MID;
      2'b11:   lim_c = C_LO;
      default: lim_c = 64'd0;
    endcase
    small_c = (nl_sel_i != 2'b00) && (64'(abs_c) < lim_c);
  end

  a_r1_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && seen_c && !dir_mode_i && !last_neg_c && neg_c |=> status_o[0]);

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && seen_c && dir_mode_i && last_neg_c && !neg_c |=> status_o[0]);

  a_r3_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && !seen_c && !status_o[0] |=> !status_o[0]);

  a_r4_noload_sets: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && small_c |=> status_o[1]);

  a_r5_acc_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_sel_i == 2'b00) |-> acc_en_o);

  a_r5_acc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && small_c |=> (nl_sel_i == 2'b00) || !acc_en_o);

  a_r6_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_o & irq_en_i)) |-> irq_o);

  a_r6_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_o & irq_en_i)) |-> !irq_o);

  a_r7_sign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && !(clr_wr_i && clr_data_i[0]) |=> status_o[0]);

  a_r7_nl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[1] && !(clr_wr_i && clr_data_i[1]) |=> status_o[1]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && small_c && clr_wr_i && clr_data_i[1] |=> status_o[1]);

endmodule

bind pwr_event_monitor pwr_event_monitor_chk #(.DW(DW), .FS(FS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .smp_valid_i (smp_valid_i),
  .smp_data_i  (smp_data_i),
  .dir_mode_i  (dir_mode_i),
  .nl_sel_i    (nl_sel_i),
  .irq_en_i    (irq_en_i),
  .clr_wr_i    (clr_wr_i),
  .clr_data_i  (clr_data_i),
  .status_o    (status_o),
  .irq_o       (irq_o),
  .acc_en_o    (acc_en_o)
);

// File: tb/sim_pwr_event_monitor.sv
`timescale 1ns/1ps
module sim_pwr_event_monitor;

  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid_i;
  logic [DW-1:0] smp_data_i;
  logic          dir_mode_i;
  logic [1:0]    nl_sel_i;
  logic [1:0]    irq_en_i;
  logic          clr_wr_i;
  logic [1:0]    clr_data_i;
  logic [1:0]    status_o;
  logic          irq_o;
  logic          acc_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwr_event_monitor #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .dir_mode_i(dir_mode_i), .nl_sel_i(nl_sel_i), .irq_en_i(irq_en_i),
    .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i), .status_o(status_o),
    .irq_o(irq_o), .acc_en_o(acc_en_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_sync;
  bit  m_seen, m_prevneg, m_nl;
  bit  m_st0, m_st1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_seen = 0; m_prevneg = 0; m_nl = 0; m_st0 = 0; m_st1 = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int v, mag, lim;
      bit ng, s0, s1;
      v   = $signed(smp_data_i);
      ng  = (v < 0);
      mag = ng ? -v : v;
      case (nl_sel_i)
        2'b01: lim = 126;
        2'b10: lim = 63;
        2'b11: lim = 31;
        default: lim = 0;
      endcase
      s0 = smp_valid_i && m_seen && (dir_mode_i ? (m_prevneg && !ng) : (!m_prevneg && ng));
      s1 = smp_valid_i && (mag < lim);
      if (clr_wr_i && clr_data_i[0]) m_st0 = 0;
      if (clr_wr_i && clr_data_i[1]) m_st1 = 0;
      if (s0) m_st0 = 1;
      if (s1) m_st1 = 1;
      if (smp_valid_i) begin
        m_seen = 1; m_prevneg = ng; m_nl = (mag < lim);
      end
    end
  end

  // Compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    begin
      bit e_acc, e_irq;
      e_acc = (nl_sel_i == 2'b00) || !m_nl;
      e_irq = (m_st0 && irq_en_i[0]) || (m_st1 && irq_en_i[1]);
      chk(status_o[0] == m_st0, "R1/R2 sign status", status_o[0], m_st0);
      chk(status_o[1] == m_st1, "R4 no-load status", status_o[1], m_st1);
      chk(acc_en_o == e_acc, "R5 acc_en", acc_en_o, e_acc);
      chk(irq_o == e_irq, "R6 irq", irq_o, e_irq);
    end
  end

  task automatic put(input bit v, input int d);
    smp_valid_i = v;
    smp_data_i  = d[DW-1:0];
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic clr(input logic [1:0] m);
    clr_wr_i = 1'b1; clr_data_i = m;
    @(negedge clk);
    clr_wr_i = 1'b0; clr_data_i = 2'b00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(status_o == 2'b00, "R9 status in reset", status_o, 0);
    chk(irq_o == 1'b0, "R9 irq in reset", irq_o, 0);
    chk(acc_en_o == 1'b1, "R9 acc_en in reset", acc_en_o, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(status_o == 2'b00, "R9 status after reset", status_o, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    smp_valid_i = 0; smp_data_i = '0; dir_mode_i = 0; nl_sel_i = 2'b00;
    irq_en_i = 2'b11; clr_wr_i = 0; clr_data_i = 2'b00;
    @(negedge clk);
    do_reset();

    // R1: positive to negative with dir 0
    put(1, 1000); put(1, -1000);
    chk(status_o[0] == 1'b1, "R1 fall sets sign flag", status_o[0], 1);
    chk(irq_o == 1'b1, "R6 irq with sign enabled", irq_o, 1);
    put(0, 500); put(1, -5);
    chk(status_o[0] == 1'b1, "R7 sign flag sticky", status_o[0], 1);
    clr(2'b10);
    chk(status_o[0] == 1'b1, "R7 clear of other bit ignored", status_o[0], 1);
    clr(2'b01);
    chk(status_o[0] == 1'b0, "R7 write-one clears", status_o[0], 0);
    chk(irq_o == 1'b0, "R6 irq drops after clear", irq_o, 0);

    // R2: negative to positive with dir 1, zero positive (R3)
    dir_mode_i = 1;
    put(1, -10); put(1, 0);
    chk(status_o[0] == 1'b1, "R2 R3 rise to zero sets flag", status_o[0], 1);
    clr(2'b01);
    put(1, -3);
    chk(status_o[0] == 1'b0, "R2 fall ignored in dir 1", status_o[0], 0);
    put(0, 5);
    chk(status_o[0] == 1'b0, "R3 invalid sample ignored", status_o[0], 0);

    // R3: first valid sample after reset
    dir_mode_i = 0;
    do_reset();
    put(1, -50);
    chk(status_o[0] == 1'b0, "R3 first sample no event", status_o[0], 0);

    // R4/R5: threshold codes
    nl_sel_i = 2'b01;
    put(1, 125);
    chk(status_o[1] == 1'b1, "R4 code 01 below 126", status_o[1], 1);
    chk(acc_en_o == 1'b0, "R5 acc off under load limit", acc_en_o, 0);
    put(1, 126);
    chk(acc_en_o == 1'b1, "R5 acc on at 126", acc_en_o, 1);
    clr(2'b10);
    put(1, -126);
    chk(status_o[1] == 1'b0, "R4 magnitude 126 not below", status_o[1], 0);
    nl_sel_i = 2'b10;
    put(1, -62);
    chk(acc_en_o == 1'b0, "R5 code 10 at -62", acc_en_o, 0);
    put(1, 63);
    chk(acc_en_o == 1'b1, "R5 code 10 at 63", acc_en_o, 1);
    nl_sel_i = 2'b11;
    put(1, 30);
    chk(acc_en_o == 1'b0, "R5 code 11 at 30", acc_en_o, 0);
    put(1, 31);
    chk(acc_en_o == 1'b1, "R5 code 11 at 31", acc_en_o, 1);
    clr(2'b10);
    nl_sel_i = 2'b00;
    put(1, 0);
    chk(status_o[1] == 1'b0, "R4 code 00 disables", status_o[1], 0);
    nl_sel_i = 2'b01;
    put(1, 5);
    nl_sel_i = 2'b00;
    #1;
    chk(acc_en_o == 1'b1, "R5 acc high once disabled", acc_en_o, 1);

    // R8: set and clear in the same cycle
    nl_sel_i = 2'b01;
    smp_valid_i = 1; smp_data_i = 24'd5; clr_wr_i = 1; clr_data_i = 2'b10;
    @(negedge clk);
    smp_valid_i = 0; clr_wr_i = 0; clr_data_i = 2'b00;
    chk(status_o[1] == 1'b1, "R8 set beats clear", status_o[1], 1);

    // R6: masking
    irq_en_i = 2'b01;
    clr(2'b01);
    #1;
    chk(irq_o == 1'b0, "R6 masked no-load", irq_o, 0);
    irq_en_i = 2'b10;
    #1;
    chk(irq_o == 1'b1, "R6 enabled no-load", irq_o, 1);
    clr(2'b11);

    // Random phase
    irq_en_i = 2'b11;
    for (int i = 0; i < 5000; i++) begin
      if ((i % 64) == 0) begin
        nl_sel_i   = 2'($urandom_range(0, 3));
        dir_mode_i = 1'($urandom_range(0, 1));
        irq_en_i   = 2'($urandom_range(0, 3));
      end
      smp_valid_i = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 7) == 0) smp_data_i = DW'($urandom);
      else smp_data_i = DW'($signed($urandom_range(0, 300)) - 150);
      clr_wr_i   = ($urandom_range(0, 5) == 0);
      clr_data_i = 2'($urandom_range(0, 3));
      @(negedge clk);
    end
    smp_valid_i = 0; clr_wr_i = 0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule